// File: doc/BRIEF.md
# Indexed Saturating Doubling Widening Multiplier

This block is a vector datapath stage. It decodes one 32-bit instruction word and runs a signed, doubling, saturating, widening multiply across a vector of up to `VLEN_MAX` bits, one cycle after the operands are presented. The vector is cut into independent 128-bit segments. In each segment, every wide result lane takes one narrow element of the first source vector. The bottom form takes the even narrow lanes and the top form takes the odd ones. Each of these is multiplied by a single narrow element of the second source vector, picked by an index from that same segment.

Two element forms exist: 16-bit sources with 32-bit results, and 32-bit sources with 64-bit results. The caller gives the active length as a count of 128-bit segments, and only those segments produce data. The register numbers and the element index that the instruction carries are also returned, so a surrounding pipeline can steer its register file. A per-operation saturation bit and a sticky saturation bit record whether any active lane clamped.

Top module: `sqdml_idx_unit`

## Requirements
- R1: An instruction is legal only when bits [31:24] = 8'h44, bit 23 = 1, bit 21 = 1 and bits [15:12] = 4'hE. Any other word sets `illegal`, drives a zero `result` and leaves `sat_any` low.
- R2: When bit 22 = 0 (16-bit sources, 32-bit results), `srcm_reg` = {1'b0, insn[18:16]} and `elem_idx` = {insn[20:19], insn[11]}.
- R3: When bit 22 = 1 (32-bit sources, 64-bit results), `srcm_reg` = insn[19:16] and `elem_idx` = {1'b0, insn[20], insn[11]}.
- R4: `dst_reg` = insn[4:0] and `srcn_reg` = insn[9:5].
- R5: Wide lane j of a segment takes narrow lane 2j of `src_n` when bit 10 = 0, and narrow lane 2j+1 when bit 10 = 1.
- R6: The multiplier element for a segment is narrow element `elem_idx` of the same 128-bit segment of `src_m`, counted from the segment's least significant bits.
- R7: Each active result lane equals 2·a·b as a signed double-width value. When both operands are the most negative narrow value, the lane becomes the largest positive wide value.
- R8: `sat_any` reports whether any active lane of the current operation clamped. `sat_sticky` is set by any such operation and is cleared only by reset.
- R9: Segment s (s = 0 at the least significant end) is active when s < `act_segs`. Inactive segments read zero and never raise saturation. Values above the segment count activate every segment.
- R10: `out_valid` is high exactly one cycle after `in_valid`. The registered outputs change only on a cycle that follows `in_valid`.
- R11: After reset, `out_valid`, `illegal`, `sat_any`, `sat_sticky` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction present this cycle |
| insn | input | 32 | Instruction word |
| act_segs | input | ACT_W | Active vector length in 128-bit segments |
| src_n | input | VLEN_MAX | First source vector (per-lane operand) |
| src_m | input | VLEN_MAX | Second source vector (indexed operand) |
| out_valid | output | 1 | Result valid strobe |
| result | output | VLEN_MAX | Wide saturated products |
| illegal | output | 1 | Instruction not recognised |
| dst_reg | output | 5 | Destination register number |
| srcn_reg | output | 5 | First source register number |
| srcm_reg | output | 4 | Second source register number |
| elem_idx | output | 3 | Decoded element index |
| sat_any | output | 1 | Saturation in this operation |
| sat_sticky | output | 1 | Saturation since reset |

## Verification
Saturation and the active-length mask can fall on the same lane in the same cycle. To provoke it, both sources are filled entirely with the most negative narrow value while `act_segs` excludes some or all segments. The outcome is judged by a clamped maximum in the active segments, zeros in the inactive ones, and `sat_any` following only the active part: low when `act_segs` is zero. The same operand pattern is also sent with an undecodable word, to show that an illegal decode overrides saturation.

// File: rtl/sqdml_pkg.sv
package sqdml_pkg;

  localparam int SEG_W    = 128;
  localparam int NW_H     = 16;
  localparam int NW_S     = 32;
  localparam int LANES_H  = SEG_W / (2 * NW_H);
  localparam int LANES_S  = SEG_W / (2 * NW_S);
  localparam int ELEMS_H  = SEG_W / NW_H;
  localparam int ELEMS_S  = SEG_W / NW_S;

  localparam logic [7:0] OPC_TOP = 8'h44;
  localparam logic [3:0] OPC_MID = 4'hE;

  typedef enum logic {
    FORM_HS = 1'b0,
    FORM_SD = 1'b1
  } form_e;

  typedef struct packed {
    logic       legal;
    form_e      form;
    logic       upper;
    logic [2:0] idx;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [3:0] rm;
  } dec_t;

endpackage

// File: rtl/sqdml_decode.sv
module sqdml_decode
  import sqdml_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);

  logic match;

  always_comb begin
    match = (insn[31:24] == OPC_TOP) && insn[23] && insn[21] &&
            (insn[15:12] == OPC_MID);
    dec.legal = match;
    dec.form  = form_e'(insn[22]);
    dec.upper = insn[10];
    dec.rd    = insn[4:0];
    dec.rn    = insn[9:5];
    if (insn[22]) begin
      dec.rm  = insn[19:16];
      dec.idx = {1'b0, insn[20], insn[11]};
    end else begin
      dec.rm  = {1'b0, insn[18:16]};
      dec.idx = {insn[20:19], insn[11]};
    end
  end

endmodule

// File: rtl/sqdml_lane.sv
module sqdml_lane #(
  parameter int NW = 16
) (
  input  logic [NW-1:0]   op_a,
  input  logic [NW-1:0]   op_b,
  output logic [2*NW-1:0] prod_o,
  output logic            clamp_o
);

  localparam logic [NW-1:0]   MOST_NEG = {1'b1, {(NW-1){1'b0}}};
  localparam logic [2*NW-1:0] MOST_POS = {1'b0, {(2*NW-1){1'b1}}};

  logic [2*NW-1:0] ext_a, ext_b, raw;

  always_comb begin
    ext_a   = {{NW{op_a[NW-1]}}, op_a};
    ext_b   = {{NW{op_b[NW-1]}}, op_b};
    raw     = ext_a * ext_b;
    clamp_o = (op_a == MOST_NEG) && (op_b == MOST_NEG);
    prod_o  = clamp_o ? MOST_POS : {raw[2*NW-2:0], 1'b0};
  end

endmodule

// File: rtl/sqdml_segment.sv
module sqdml_segment
  import sqdml_pkg::*;
(
  input  logic [SEG_W-1:0] seg_n,
  input  logic [SEG_W-1:0] seg_m,
  input  form_e            form,
  input  logic             upper,
  input  logic [2:0]       idx,
  output logic [SEG_W-1:0] seg_res,
  output logic             seg_clamp
);

  logic [NW_H-1:0] m_h [ELEMS_H];
  logic [NW_S-1:0] m_s [ELEMS_S];
  logic [NW_H-1:0] pick_h;
  logic [NW_S-1:0] pick_s;
  logic [SEG_W-1:0]   res_h, res_s;
  logic [LANES_H-1:0] clamp_h;
  logic [LANES_S-1:0] clamp_s;

  for (genvar e = 0; e < ELEMS_H; e++) begin : g_mh
    assign m_h[e] = seg_m[e*NW_H +: NW_H];
  end
  for (genvar e = 0; e < ELEMS_S; e++) begin : g_ms
    assign m_s[e] = seg_m[e*NW_S +: NW_S];
  end

  assign pick_h = m_h[idx];
  assign pick_s = m_s[idx[1:0]];

  for (genvar j = 0; j < LANES_H; j++) begin : g_lh
    logic [NW_H-1:0] a_sel;
    assign a_sel = upper ? seg_n[(2*j+1)*NW_H +: NW_H] : seg_n[(2*j)*NW_H +: NW_H];
    sqdml_lane #(.NW(NW_H)) u_lane (
      .op_a    (a_sel),
      .op_b    (pick_h),
      .prod_o  (res_h[j*2*NW_H +: 2*NW_H]),
      .clamp_o (clamp_h[j])
    );
  end

  for (genvar j = 0; j < LANES_S; j++) begin : g_ls
    logic [NW_S-1:0] a_sel;
    assign a_sel = upper ? seg_n[(2*j+1)*NW_S +: NW_S] : seg_n[(2*j)*NW_S +: NW_S];
    sqdml_lane #(.NW(NW_S)) u_lane (
      .op_a    (a_sel),
      .op_b    (pick_s),
      .prod_o  (res_s[j*2*NW_S +: 2*NW_S]),
      .clamp_o (clamp_s[j])
    );
  end

  always_comb begin
    if (form == FORM_SD) begin
      seg_res   = res_s;
      seg_clamp = |clamp_s;
    end else begin
      seg_res   = res_h;
      seg_clamp = |clamp_h;
    end
  end

endmodule

// File: rtl/sqdml_idx_unit.sv
module sqdml_idx_unit
  import sqdml_pkg::*;
#(
  parameter int VLEN_MAX = 2048,
  localparam int NSEG    = VLEN_MAX / SEG_W,
  localparam int ACT_W   = $clog2(NSEG + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [31:0]         insn,
  input  logic [ACT_W-1:0]    act_segs,
  input  logic [VLEN_MAX-1:0] src_n,
  input  logic [VLEN_MAX-1:0] src_m,
  output logic                out_valid,
  output logic [VLEN_MAX-1:0] result,
  output logic                illegal,
  output logic [4:0]          dst_reg,
  output logic [4:0]          srcn_reg,
  output logic [3:0]          srcm_reg,
  output logic [2:0]          elem_idx,
  output logic                sat_any,
  output logic                sat_sticky
);

  dec_t dec;
  logic [VLEN_MAX-1:0] res_next;
  logic [NSEG-1:0]     seg_clamp, seg_on;
  logic                clamp_next;

  sqdml_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] part;
    sqdml_segment u_seg (
      .seg_n     (src_n[s*SEG_W +: SEG_W]),
      .seg_m     (src_m[s*SEG_W +: SEG_W]),
      .form      (dec.form),
      .upper     (dec.upper),
      .idx       (dec.idx),
      .seg_res   (part),
      .seg_clamp (seg_clamp[s])
    );
    assign seg_on[s] = dec.legal && (act_segs > ACT_W'(s));
    assign res_next[s*SEG_W +: SEG_W] = seg_on[s] ? part : '0;
  end

  assign clamp_next = |(seg_clamp & seg_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      illegal    <= 1'b0;
      dst_reg    <= '0;
      srcn_reg   <= '0;
      srcm_reg   <= '0;
      elem_idx   <= '0;
      sat_any    <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_next;
        illegal    <= !dec.legal;
        dst_reg    <= dec.rd;
        srcn_reg   <= dec.rn;
        srcm_reg   <= dec.rm;
        elem_idx   <= dec.idx;
        sat_any    <= clamp_next;
        sat_sticky <= sat_sticky | clamp_next;
      end
    end
  end

endmodule

// File: rtl/sqdml_idx_chk.sv
module sqdml_idx_chk
  import sqdml_pkg::*;
#(
  parameter int VLEN_MAX = 2048,
  localparam int NSEG    = VLEN_MAX / SEG_W,
  localparam int ACT_W   = $clog2(NSEG + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [ACT_W-1:0]    act_segs,
  input logic                out_valid,
  input logic [VLEN_MAX-1:0] result,
  input logic                illegal,
  input logic                sat_any,
  input logic                sat_sticky
);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_result_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(sat_any));

  assert_sticky_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    sat_sticky |=> sat_sticky);

  assert_sat_implies_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    sat_any |-> sat_sticky);

  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && illegal |-> (result == '0) && !sat_any);

  assert_top_seg_off_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_valid) && ($past(act_segs) < ACT_W'(NSEG))
      |-> result[VLEN_MAX-1 -: SEG_W] == '0);

endmodule

bind sqdml_idx_unit sqdml_idx_chk #(.VLEN_MAX(VLEN_MAX)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .act_segs   (act_segs),
  .out_valid  (out_valid),
  .result     (result),
  .illegal    (illegal),
  .sat_any    (sat_any),
  .sat_sticky (sat_sticky)
);

// File: tb/sqdml_idx_unit_bench.sv
module sqdml_idx_unit_bench;

  localparam int VL    = 256;
  localparam int NSEG  = VL / 128;
  localparam int ACT_W = $clog2(NSEG + 1);

  typedef struct packed {
    logic       wide;
    logic       upper;
    logic [2:0] idx;
    logic [3:0] rm;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [1:0] act;
    logic [15:0] seed;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TABLE [NVEC] = '{
    '{1'b0, 1'b0, 3'd3, 4'd5,  5'd1,  5'd2,  2'd2, 16'h0001},
    '{1'b0, 1'b1, 3'd7, 4'd7,  5'd31, 5'd0,  2'd2, 16'h1234},
    '{1'b1, 1'b0, 3'd2, 4'd12, 5'd9,  5'd17, 2'd2, 16'hBEEF},
    '{1'b1, 1'b1, 3'd3, 4'd15, 5'd0,  5'd31, 2'd2, 16'h0F0F},
    '{1'b0, 1'b0, 3'd0, 4'd1,  5'd4,  5'd8,  2'd1, 16'h7777},
    '{1'b1, 1'b1, 3'd1, 4'd3,  5'd5,  5'd6,  2'd0, 16'hA5A5},
    '{1'b0, 1'b1, 3'd5, 4'd2,  5'd10, 5'd20, 2'd3, 16'h5A5A},
    '{1'b1, 1'b0, 3'd0, 4'd8,  5'd11, 5'd12, 2'd1, 16'hC001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [ACT_W-1:0] act_segs = '0;
  logic [VL-1:0] src_n = '0, src_m = '0;
  logic out_valid, illegal, sat_any, sat_sticky;
  logic [VL-1:0] result;
  logic [4:0] dst_reg, srcn_reg;
  logic [3:0] srcm_reg;
  logic [2:0] elem_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sqdml_idx_unit #(.VLEN_MAX(VL)) u_sqdml_idx_unit (
    .clk, .rst, .in_valid, .insn, .act_segs, .src_n, .src_m,
    .out_valid, .result, .illegal, .dst_reg, .srcn_reg, .srcm_reg,
    .elem_idx, .sat_any, .sat_sticky
  );

  task automatic chk(input bit ok, input string req, input logic [VL-1:0] got,
                     input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input logic wide, input logic upper,
      input logic [2:0] idx, input logic [3:0] rm, input logic [4:0] rd,
      input logic [4:0] rn);
    logic [31:0] w;
    w = 32'h44A0_E000;
    w[22] = wide;
    w[10] = upper;
    w[4:0] = rd;
    w[9:5] = rn;
    if (wide) begin
      w[19:16] = rm;
      w[20] = idx[1];
      w[11] = idx[0];
    end else begin
      w[18:16] = rm[2:0];
      w[20:19] = idx[2:1];
      w[11] = idx[0];
    end
    return w;
  endfunction

  function automatic logic [VL-1:0] fill(input logic [31:0] seed);
    logic [VL-1:0] v;
    logic [31:0] x;
    x = seed;
    for (int k = 0; k < VL / 32; k++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      v[k*32 +: 32] = x;
    end
    return v;
  endfunction

  task automatic model(input logic [31:0] ins, input logic [VL-1:0] a,
      input logic [VL-1:0] b, input int act, output logic [VL-1:0] r,
      output logic s, output logic ill);
    logic ok;
    int t, ix;
    r = '0;
    s = 1'b0;
    ok = (ins[31:24] == 8'h44) && ins[23] && ins[21] && (ins[15:12] == 4'hE);
    ill = !ok;
    if (!ok) return;
    t = int'(ins[10]);
    for (int sg = 0; sg < NSEG; sg++) begin
      if (sg < act) begin
        if (!ins[22]) begin
          ix = int'({ins[20:19], ins[11]});
          for (int j = 0; j < 4; j++) begin
            shortint x, y;
            int p;
            x = a[sg*128 + (2*j+t)*16 +: 16];
            y = b[sg*128 + ix*16 +: 16];
            if (x == -16'sd32768 && y == -16'sd32768) begin
              r[sg*128 + j*32 +: 32] = 32'h7FFF_FFFF;
              s = 1'b1;
            end else begin
              p = int'(x) * int'(y) * 2;
              r[sg*128 + j*32 +: 32] = p;
            end
          end
        end else begin
          ix = int'({ins[20], ins[11]});
          for (int j = 0; j < 2; j++) begin
            int x, y;
            longint p;
            x = a[sg*128 + (2*j+t)*32 +: 32];
            y = b[sg*128 + ix*32 +: 32];
            if (x == 32'sh8000_0000 && y == 32'sh8000_0000) begin
              r[sg*128 + j*64 +: 64] = 64'h7FFF_FFFF_FFFF_FFFF;
              s = 1'b1;
            end else begin
              p = longint'(x) * longint'(y) * 2;
              r[sg*128 + j*64 +: 64] = p;
            end
          end
        end
      end
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [VL-1:0] a,
      input logic [VL-1:0] b, input int act);
    @(negedge clk);
    insn = ins;
    src_n = a;
    src_m = b;
    act_segs = ACT_W'(act);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_check(input logic [31:0] ins, input logic [VL-1:0] a,
      input logic [VL-1:0] b, input int act, input string tag);
    logic [VL-1:0] er;
    logic es, ei;
    model(ins, a, b, act, er, es, ei);
    issue(ins, a, b, act);
    chk(out_valid === 1'b1, {tag, " R10 valid"}, VL'(out_valid), VL'(1));
    chk(result === er, {tag, " R5 R6 R7 R9 result"}, result, er);
    chk(sat_any === es, {tag, " R8 sat"}, VL'(sat_any), VL'(es));
    chk(illegal === ei, {tag, " R1 illegal"}, VL'(illegal), VL'(ei));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VL-1:0] mn16, mn32, hold;
    logic [31:0] w;
    mn16 = {(VL/16){16'h8000}};
    mn32 = {(VL/32){32'h8000_0000}};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid === 1'b0 && illegal === 1'b0 && sat_any === 1'b0,
        "R11 flags", VL'({out_valid, illegal, sat_any}), '0);
    chk(sat_sticky === 1'b0 && result === '0, "R11 result/sticky", result, '0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      vec_t e;
      e = TABLE[v];
      w = mk_insn(e.wide, e.upper, e.idx, e.rm, e.rd, e.rn);
      run_check(w, fill({16'h0, e.seed}), fill({e.seed, 16'h5555}), int'(e.act),
                $sformatf("vec%0d", v));
      chk(dst_reg === e.rd && srcn_reg === e.rn, "R4 fields",
          VL'({dst_reg, srcn_reg}), VL'({e.rd, e.rn}));
      if (e.wide) begin
        chk(srcm_reg === e.rm && elem_idx === {1'b0, e.idx[1:0]}, "R3 fields",
            VL'({srcm_reg, elem_idx}), VL'({e.rm, 1'b0, e.idx[1:0]}));
      end else begin
        chk(srcm_reg === {1'b0, e.rm[2:0]} && elem_idx === e.idx, "R2 fields",
            VL'({srcm_reg, elem_idx}), VL'({1'b0, e.rm[2:0], e.idx}));
      end
    end

    // R10 hold: idle cycle leaves outputs unchanged
    hold = result;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 strobe low", VL'(out_valid), '0);
    chk(result === hold, "R10 hold", result, hold);

    // R7 R8 saturation in 16-bit form, all segments active
    run_check(mk_insn(1'b0, 1'b1, 3'd6, 4'd0, 5'd3, 5'd4), mn16, mn16, NSEG, "sat16");
    chk(sat_sticky === 1'b1, "R8 sticky set", VL'(sat_sticky), VL'(1));
    // R7 saturation in 32-bit form, upper segment inactive (R9)
    run_check(mk_insn(1'b1, 1'b0, 3'd1, 4'd9, 5'd3, 5'd4), mn32, mn32, 1, "sat32");
    // R9 saturating operands in fully inactive vector
    run_check(mk_insn(1'b0, 1'b0, 3'd2, 4'd0, 5'd3, 5'd4), mn16, mn16, 0, "sat_masked");
    chk(sat_sticky === 1'b1, "R8 sticky holds", VL'(sat_sticky), VL'(1));
    // R7 one operand most negative only: no clamp
    run_check(mk_insn(1'b0, 1'b0, 3'd1, 4'd0, 5'd3, 5'd4), mn16,
              {(VL/16){16'h7FFF}}, NSEG, "near_sat");
    // R1 illegal: size bit 23 clear, and wrong opcode nibble
    w = mk_insn(1'b0, 1'b0, 3'd0, 4'd0, 5'd1, 5'd1);
    w[23] = 1'b0;
    run_check(w, mn16, mn16, NSEG, "illegal_size");
    w = mk_insn(1'b1, 1'b0, 3'd0, 4'd0, 5'd1, 5'd1);
    w[12] = 1'b1;
    run_check(w, mn32, mn32, NSEG, "illegal_opc");
    w = mk_insn(1'b1, 1'b0, 3'd0, 4'd0, 5'd1, 5'd1);
    w[21] = 1'b0;
    run_check(w, fill(32'h99), fill(32'h77), NSEG, "illegal_b21");

    // R8 sticky cleared only by reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(sat_sticky === 1'b0 && out_valid === 1'b0, "R11 R8 reset clears",
        VL'({sat_sticky, out_valid}), '0);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule